// File: doc/BRIEF.md
# DMA Stream Event Flag Register

This block keeps the sticky interrupt event flags of four DMA streams. Each stream reports five kinds of event: FIFO error, direct-mode error, transfer error, half transfer and transfer complete. An event arrives as a one-cycle pulse on the stream's event input and sets the matching flag. The flag stays set until software clears it.

Software reads all twenty flags in one 32-bit read-only status word at offset 0x00. It clears flags by writing ones to a separate write-one-to-clear register at offset 0x08. The register port takes 32-bit word accesses only. It has an address, a write strobe, four byte enables, write data and combinational read data.

Each stream also drives an interrupt line. The line is high when the stream has at least one flag set and the stream's enable input is high.

Top module: `dmaflag_status`

## Requirements
- R1: After a synchronous active-high reset, every flag is clear, the status word reads 0x0000_0000 and every interrupt line is low.
- R2: In the status word, stream n has a six-bit group starting at bit 0, 6, 16 or 22 for n = 0, 1, 2, 3. Inside a group, bit +0 is FIFO error, +2 is direct-mode error, +3 is transfer error, +4 is half transfer and +5 is transfer complete.
- R3: Bits 31:28, bits 15:12 and bit +1 of every group always read as zero.
- R4: An event pulse sets its flag on the next clock edge. The flag then stays set while no clear reaches it.
- R5: A full-word write to offset 0x08 clears every flag whose bit position holds a 1 in the write data. Flags at positions holding 0 are left unchanged.
- R6: When an event pulse and a clear of the same flag land in the same cycle, the flag is set afterwards.
- R7: A write to offset 0x00 changes no flag.
- R8: An access whose byte enables are not all four set (0xF) changes no flag, and such a read returns zero.
- R9: A read of offset 0x08, or of any offset other than 0x00, returns zero.
- R10: A stream's interrupt line equals its enable input ANDed with the OR of that stream's five flags. The line changes on the same edge that changes the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_be | input | 4 | Byte enables; only 4'hF is a legal access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ev_fifo_err | input | 4 | FIFO error event pulse, one bit per stream |
| ev_dm_err | input | 4 | Direct-mode error event pulse, one bit per stream |
| ev_xfer_err | input | 4 | Transfer error event pulse, one bit per stream |
| ev_half | input | 4 | Half transfer event pulse, one bit per stream |
| ev_done | input | 4 | Transfer complete event pulse, one bit per stream |
| irq_en | input | 4 | Interrupt enable, one bit per stream |
| irq | output | 4 | Interrupt line, one bit per stream |

## Verification
A flag that is lost, sticks, or sits in the wrong group shows up on the very next status read after the edge that should have changed it. It also shows up on that stream's interrupt line in the same cycle. The bench fires every event kind on every stream one at a time, so a swapped or misplaced bit reads back at a position the layout does not predict. A wrong priority between set and clear, or a clear decoded at the wrong offset or with partial byte enables, leaves a flag in the wrong state. That error is visible on the read that directly follows the collision or the ignored write.

// File: rtl/dmaflag_pkg.sv
package dmaflag_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned BE_W      = DATA_W / 8;
    localparam int unsigned GROUP_W   = 6;
    localparam int unsigned HALF_SPAN = 16;
    localparam int unsigned KIND_N    = 5;

    typedef struct packed {
        logic done;
        logic half;
        logic xfer_err;
        logic dm_err;
        logic fifo_err;
    } evt_flags_t;

    typedef enum logic [1:0] {
        RD_NONE   = 2'd0,
        RD_STATUS = 2'd1,
        RD_CLEAR  = 2'd2
    } rd_sel_t;

    // Streams pair up inside each 16-bit half of the word.
    function automatic int unsigned group_base(int unsigned s);
        return (s % 2) * GROUP_W + (s / 2) * HALF_SPAN;
    endfunction

    function automatic logic [GROUP_W-1:0] pack_group(evt_flags_t f);
        return {f.done, f.half, f.xfer_err, f.dm_err, 1'b0, f.fifo_err};
    endfunction

    function automatic evt_flags_t unpack_group(logic [GROUP_W-1:0] g);
        evt_flags_t f;
        f.fifo_err = g[0];
        f.dm_err   = g[2];
        f.xfer_err = g[3];
        f.half     = g[4];
        f.done     = g[5];
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] used_mask(int unsigned ns);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < ns; i++) begin
            m[group_base(i) +: GROUP_W] = pack_group('1);
        end
        return m;
    endfunction

endpackage

// File: rtl/dmaflag_bus.sv
module dmaflag_bus
    import dmaflag_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned NUM_STREAMS = 4,
    parameter int unsigned STATUS_OFS  = 0,
    parameter int unsigned CLEAR_OFS   = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         wr,
    input  logic [BE_W-1:0]              be,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [DATA_W-1:0]            status_word,
    output evt_flags_t                   clr [NUM_STREAMS],
    output logic [DATA_W-1:0]            rdata
);

    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] CL_A = ADDR_W'(CLEAR_OFS);

    logic    full_word;
    logic    clr_hit;
    rd_sel_t rsel;

    assign full_word = (be == {BE_W{1'b1}});
    assign clr_hit   = wr && full_word && (addr == CL_A);

    always_comb begin
        for (int unsigned i = 0; i < NUM_STREAMS; i++) begin
            clr[i] = clr_hit ? unpack_group(wdata[group_base(i) +: GROUP_W])
                             : evt_flags_t'('0);
        end
    end

    always_comb begin
        rsel = RD_NONE;
        if (full_word) begin
            if (addr == ST_A)      rsel = RD_STATUS;
            else if (addr == CL_A) rsel = RD_CLEAR;
        end
    end

    always_comb begin
        unique case (rsel)
            RD_STATUS: rdata = status_word;
            default:   rdata = '0;
        endcase
    end

    assert_clear_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (addr != ST_A) |-> (rdata == '0));

    assert_partial_no_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (be != {BE_W{1'b1}}) |-> (clr[0] == '0 && rdata == '0));

endmodule

// File: rtl/dmaflag_stream.sv
module dmaflag_stream
    import dmaflag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  evt_flags_t set,
    input  evt_flags_t clr,
    input  logic       irq_en,
    output evt_flags_t flags,
    output logic       irq
);

    evt_flags_t flags_q;
    logic [KIND_N-1:0] set_v, clr_v, flg_v;

    assign set_v = set;
    assign clr_v = clr;
    assign flg_v = flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= evt_flags_t'((flg_v & ~clr_v) | set_v);
    end

    assign flags = flags_q;
    assign irq   = irq_en && (flg_v != '0);

    assert_set_lands_R4: assert property (@(posedge clk) disable iff (rst)
        (set_v != '0) |=> ((flg_v & $past(set_v)) == $past(set_v)));

    assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (set_v == '0 && clr_v == '0) |=> $stable(flg_v));

    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (rst)
        ((clr_v & ~set_v) != '0) |=> ((flg_v & $past(clr_v & ~set_v)) == '0));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        ((set_v & clr_v) != '0) |=> ((flg_v & $past(set_v & clr_v)) == $past(set_v & clr_v)));

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

endmodule

// File: rtl/dmaflag_status.sv
module dmaflag_status
    import dmaflag_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned NUM_STREAMS = 4,
    parameter int unsigned STATUS_OFS  = 0,
    parameter int unsigned CLEAR_OFS   = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic [3:0]             bus_be,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NUM_STREAMS-1:0] ev_fifo_err,
    input  logic [NUM_STREAMS-1:0] ev_dm_err,
    input  logic [NUM_STREAMS-1:0] ev_xfer_err,
    input  logic [NUM_STREAMS-1:0] ev_half,
    input  logic [NUM_STREAMS-1:0] ev_done,
    input  logic [NUM_STREAMS-1:0] irq_en,
    output logic [NUM_STREAMS-1:0] irq
);

    localparam logic [DATA_W-1:0] USED = used_mask(NUM_STREAMS);

    evt_flags_t        clr_g [NUM_STREAMS];
    evt_flags_t        flg_g [NUM_STREAMS];
    logic [DATA_W-1:0] status_word;

    dmaflag_bus #(
        .ADDR_W(ADDR_W), .NUM_STREAMS(NUM_STREAMS),
        .STATUS_OFS(STATUS_OFS), .CLEAR_OFS(CLEAR_OFS)
    ) u_bus (
        .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .be(bus_be),
        .wdata(bus_wdata), .status_word(status_word),
        .clr(clr_g), .rdata(bus_rdata)
    );

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
        evt_flags_t set_g;
        always_comb begin
            set_g.fifo_err = ev_fifo_err[g];
            set_g.dm_err   = ev_dm_err[g];
            set_g.xfer_err = ev_xfer_err[g];
            set_g.half     = ev_half[g];
            set_g.done     = ev_done[g];
        end
        dmaflag_stream u_str (
            .clk(clk), .rst(rst), .set(set_g), .clr(clr_g[g]),
            .irq_en(irq_en[g]), .flags(flg_g[g]), .irq(irq[g])
        );
    end

    always_comb begin
        status_word = '0;
        for (int unsigned i = 0; i < NUM_STREAMS; i++) begin
            status_word[group_base(i) +: GROUP_W] = pack_group(flg_g[i]);
        end
    end

    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (rst)
        ((bus_rdata & ~USED) == '0));

    assert_reset_clean_R1: assert property (@(posedge clk)
        rst |=> (status_word == '0));

    assert_status_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(STATUS_OFS)) |-> (clr_g[0] == '0 && clr_g[NUM_STREAMS-1] == '0));

endmodule

// File: tb/dmaflag_status_tb.sv
`timescale 1ns/1ps
module dmaflag_status_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  ev_fifo_err = '0, ev_dm_err = '0, ev_xfer_err = '0, ev_half = '0, ev_done = '0;
    logic [3:0]  irq_en = 4'hF;
    logic [3:0]  irq;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [31:0] model = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    event        smp;

    always #2.5 clk = ~clk;

    dmaflag_status u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_fifo_err(ev_fifo_err), .ev_dm_err(ev_dm_err), .ev_xfer_err(ev_xfer_err),
        .ev_half(ev_half), .ev_done(ev_done), .irq_en(irq_en), .irq(irq)
    );

    // kind: 0 FIFO err, 1 direct-mode err, 2 transfer err, 3 half, 4 done
    function automatic int pos(int s, int k);
        int base, off;
        case (s) 0: base = 0; 1: base = 6; 2: base = 16; default: base = 22; endcase
        case (k) 0: off = 0; 1: off = 2; 2: off = 3; 3: off = 4; default: off = 5; endcase
        return base + off;
    endfunction

    function automatic logic [3:0] exp_irq();
        logic [3:0] r;
        for (int s = 0; s < 4; s++) begin
            logic any;
            any = 1'b0;
            for (int k = 0; k < 5; k++) any |= model[pos(s, k)];
            r[s] = any & irq_en[s];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard as the design presents read data
    initial forever begin
        @(smp);
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end

    task automatic rd(logic [7:0] a, logic [3:0] be, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wr = 1'b0;
        exp_q.push_back(exp); tag_q.push_back(tag);
        #1 -> smp;
    endtask

    task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic set_ev(int s, int k, logic v);
        case (k)
            0: ev_fifo_err[s] = v;
            1: ev_dm_err[s]   = v;
            2: ev_xfer_err[s] = v;
            3: ev_half[s]     = v;
            default: ev_done[s] = v;
        endcase
    endtask

    task automatic pulse(int s, int k);
        @(negedge clk);
        set_ev(s, k, 1'b1);
        @(negedge clk);
        set_ev(s, k, 1'b0);
        model[pos(s, k)] = 1'b1;
    endtask

    task automatic chk_irq(string tag);
        #1 check(tag, {28'd0, irq}, {28'd0, exp_irq()});
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] used;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(8'h00, 4'hF, 32'h0, "R1 status after reset");
        chk_irq("R1 irq after reset");

        // each event kind on each stream alone
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 5; k++) begin
                pulse(s, k);
                rd(8'h00, 4'hF, model, "R2 R4 flag position");
                chk_irq("R10 irq follows flags");
            end
        end
        rd(8'h00, 4'hF, model, "R4 flags stay set");

        used = '0;
        for (int s = 0; s < 4; s++) for (int k = 0; k < 5; k++) used[pos(s, k)] = 1'b1;
        check("R3 all flags set equals layout", model, used);
        rd(8'h00, 4'hF, used, "R3 reserved bits read zero");

        wr(8'h00, 4'hF, 32'hFFFF_FFFF);
        rd(8'h00, 4'hF, model, "R7 status write ignored");
        wr(8'h08, 4'h7, 32'hFFFF_FFFF);
        rd(8'h00, 4'hF, model, "R8 partial write no clear");
        rd(8'h00, 4'h7, 32'h0, "R8 partial read zero");
        rd(8'h08, 4'hF, 32'h0, "R9 clear reg reads zero");
        rd(8'h04, 4'hF, 32'h0, "R9 other offset reads zero");

        wr(8'h08, 4'hF, 32'h0);
        rd(8'h00, 4'hF, model, "R5 zero write no effect");
        wr(8'h08, 4'hF, 32'h0000_0FC1);
        model &= ~32'h0000_0FC1;
        rd(8'h00, 4'hF, model, "R5 partial clear");
        chk_irq("R10 irq after partial clear");
        wr(8'h08, 4'hF, 32'hFFFF_FFFF);
        model = '0;
        rd(8'h00, 4'hF, 32'h0, "R5 clear all");
        chk_irq("R10 irq low when clear");

        // set and clear on the same flag in one cycle
        @(negedge clk);
        ev_half[2] = 1'b1;
        bus_addr = 8'h08; bus_be = 4'hF; bus_wdata = 32'h1 << pos(2, 3); bus_wr = 1'b1;
        @(negedge clk);
        ev_half[2] = 1'b0; bus_wr = 1'b0;
        model[pos(2, 3)] = 1'b1;
        rd(8'h00, 4'hF, model, "R6 set wins over clear");

        irq_en = 4'b1011;
        chk_irq("R10 irq masked by enable");
        irq_en = 4'hF;
        chk_irq("R10 irq with enable");

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        rd(8'h00, 4'hF, 32'h0, "R1 status after second reset");

        @(negedge clk); @(negedge clk);
        check("R4 scoreboard drained", 32'(exp_q.size()), 32'h0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule